// File: doc/BRIEF.md
# On-Off-Keyed Pulse-Width Command Encoder

This block turns a short remote-control command into the carrier on/off envelope for a low-rate transmitter. A host presents an 8-bit keycode and a repeat count and pulses `start`. The block then sends a fixed 16-bit device address, followed by the keycode and then a trailing zero bit. Each part goes out most significant bit first. The block drives one carrier-enable line, and the RF stage downstream does nothing else with it.

Every bit takes the same time: four equal slots. A one keeps the carrier on for three slots and off for the last. A zero keeps it on for the first slot only. The zeros at the front of the address act as the receiver's sync, so no separate preamble is sent. The slot length is a whole number of system clock cycles, set by a parameter. With a 400 µs slot the bit rate comes to about 600 bits per second. Bit 7 of the keycode is the combination-key flag, and the block passes it through unchanged.

While the block is sending, `busy` stays high. After the last slot of the last repetition, `done` pulses for one cycle. The frame can be sent several times back to back.

Top module: `ook_frame_tx`

## Requirements
- R1: After reset, `carrier_en`, `busy` and `done` are all low.
- R2: A logic-1 bit drives `carrier_en` high for the first three slots of the bit and low for the fourth.
- R3: A logic-0 bit drives `carrier_en` high for the first slot of the bit and low for the other three.
- R4: Every slot lasts exactly CLK_DIV clock cycles, and every bit lasts four slots whatever its value.
- R5: A frame holds 25 bits in this order: the address 0x0035 (16 bits, MSB first), then `keycode` (MSB first), then one 0 bit.
- R6: When `start` is sampled high while idle, `busy` is high from the next cycle until the last slot ends. `done` is high for exactly one cycle, in the cycle after the last slot, with `busy` low.
- R7: A `repeat_cnt` of N sends N frames back to back with no gap between them. A `repeat_cnt` of 0 sends one frame.
- R8: While `busy` is high, `start` pulses and changes on `keycode` or `repeat_cnt` do not alter the envelope being sent.
- R9: `carrier_en` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transmission; taken only while idle |
| keycode | input | 8 | Command byte, captured when start is taken |
| repeat_cnt | input | REP_W | Number of frames to send (0 counts as 1) |
| carrier_en | output | 1 | Carrier on/off envelope |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle pulse when the last frame ends |

## Verification
The bench sends every one of the 256 keycodes and compares the envelope in every cycle against a pattern it computes itself from the slot and bit arithmetic.

Several faults would show up in that comparison:
- Swapped one/zero patterns would misplace the falling edges.
- A dropped trailing bit or a wrong address constant would shorten the frame or shift its pattern.
- An off-by-one in the slot divider would stretch each slot.

The repeat tests use counts of 0, 2 and 3. A design that got the repeat logic wrong would either insert an idle gap between frames or stop one frame early or late.

One run injects a `start` pulse and a new keycode partway through a frame. A design that re-arms on that pulse, or reads the keycode live instead of capturing it, would corrupt the rest of the envelope.

// File: rtl/ook_pkg.sv
package ook_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ook_state_e;
endpackage

// File: rtl/ook_slot_timer.sv
module ook_slot_timer #(
    parameter int DIV = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end
);
    localparam int CNT_W = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (!run) begin
            tm_d.cnt = '0;
        end else if (tm_q.cnt == LAST) begin
            tm_d.cnt = '0;
        end else begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign slot_end = run && (tm_q.cnt == LAST);
endmodule

// File: rtl/ook_bit_shaper.sv
module ook_bit_shaper #(
    parameter int SLOTS   = 4,
    parameter int ON_ONE  = 3,
    parameter int ON_ZERO = 1
) (
    input  logic                      enable,
    input  logic                      bit_val,
    input  logic [$clog2(SLOTS)-1:0]  slot_idx,
    output logic                      level
);
    localparam int SW = $clog2(SLOTS);
    localparam logic [SW:0] HI_ONE  = (SW+1)'(ON_ONE);
    localparam logic [SW:0] HI_ZERO = (SW+1)'(ON_ZERO);

    logic [SW:0] limit;

    always_comb begin
        limit = bit_val ? HI_ONE : HI_ZERO;
        level = enable && ({1'b0, slot_idx} < limit);
    end
endmodule

// File: rtl/ook_frame_seq.sv
module ook_frame_seq
    import ook_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR     = 16'h0035,
    parameter int              KEY_W      = 8,
    parameter int              TRAIL_BITS = 1,
    parameter int              REP_W      = 3,
    parameter int              SLOTS      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [KEY_W-1:0]         keycode,
    input  logic [REP_W-1:0]         repeat_cnt,
    input  logic                     slot_end,
    output logic                     busy,
    output logic                     done,
    output logic                     cur_bit,
    output logic [$clog2(SLOTS)-1:0] slot_idx
);
    localparam int FRAME_W = ADDR_W + KEY_W + TRAIL_BITS;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        ook_state_e         state;
        logic [FRAME_W-1:0] frame;
        logic [BIT_W-1:0]   bit_idx;
        logic [SLOT_W-1:0]  slot;
        logic [REP_W-1:0]   reps;
        logic               done;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.state)
            ST_IDLE: begin
                if (start) begin
                    sq_d.state   = ST_SEND;
                    sq_d.frame   = {ADDR, keycode, {TRAIL_BITS{1'b0}}};
                    sq_d.bit_idx = '0;
                    sq_d.slot    = '0;
                    sq_d.reps    = (repeat_cnt == '0) ? REP_W'(1) : repeat_cnt;
                end
            end
            ST_SEND: begin
                if (slot_end) begin
                    if (sq_q.slot == LAST_SLOT) begin
                        sq_d.slot = '0;
                        if (sq_q.bit_idx == LAST_BIT) begin
                            sq_d.bit_idx = '0;
                            if (sq_q.reps == REP_W'(1)) begin
                                sq_d.state = ST_IDLE;
                                sq_d.done  = 1'b1;
                            end else begin
                                sq_d.reps = sq_q.reps - 1'b1;
                            end
                        end else begin
                            sq_d.bit_idx = sq_q.bit_idx + 1'b1;
                        end
                    end else begin
                        sq_d.slot = sq_q.slot + 1'b1;
                    end
                end
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q       <= '0;
            sq_q.state <= ST_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy     = (sq_q.state == ST_SEND);
    assign done     = sq_q.done;
    assign cur_bit  = sq_q.frame[LAST_BIT - sq_q.bit_idx];
    assign slot_idx = sq_q.slot;
endmodule

// File: rtl/ook_frame_tx.sv
module ook_frame_tx #(
    parameter int CLK_DIV = 20000,
    parameter int REP_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       keycode,
    input  logic [REP_W-1:0] repeat_cnt,
    output logic             carrier_en,
    output logic             busy,
    output logic             done
);
    localparam int SLOTS  = 4;
    localparam int SLOT_W = $clog2(SLOTS);

    logic              slot_end;
    logic              cur_bit;
    logic [SLOT_W-1:0] slot_idx;

    ook_slot_timer #(.DIV(CLK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .slot_end (slot_end)
    );

    ook_frame_seq #(
        .ADDR_W     (16),
        .ADDR       (16'h0035),
        .KEY_W      (8),
        .TRAIL_BITS (1),
        .REP_W      (REP_W),
        .SLOTS      (SLOTS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .keycode    (keycode),
        .repeat_cnt (repeat_cnt),
        .slot_end   (slot_end),
        .busy       (busy),
        .done       (done),
        .cur_bit    (cur_bit),
        .slot_idx   (slot_idx)
    );

    ook_bit_shaper #(.SLOTS(SLOTS), .ON_ONE(3), .ON_ZERO(1)) u_shaper (
        .enable   (busy),
        .bit_val  (cur_bit),
        .slot_idx (slot_idx),
        .level    (carrier_en)
    );
endmodule

// File: rtl/ook_frame_tx_chk.sv
module ook_frame_tx_chk #(
    parameter int DIV   = 20000,
    parameter int SLOTS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic carrier_en,
    input logic busy,
    input logic done
);
    localparam int BIT_CYC = DIV * SLOTS;

    int phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 0;
        end else if (busy) begin
            phase_q <= (phase_q == BIT_CYC - 1) ? 0 : phase_q + 1;
        end else begin
            phase_q <= 0;
        end
    end

    assert_idle_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !carrier_en);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_bit_leads_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase_q == 0) |-> carrier_en);

    assert_bit_tail_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase_q >= (SLOTS - 1) * DIV) |-> !carrier_en);

    assert_slot_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (phase_q % DIV) != 0) |-> $stable(carrier_en));
endmodule

bind ook_frame_tx ook_frame_tx_chk #(.DIV(CLK_DIV), .SLOTS(4)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_en (carrier_en),
    .busy       (busy),
    .done       (done)
);

// File: tb/ook_frame_tx_test.sv
`timescale 1ns/1ps
module ook_frame_tx_test;
    localparam int DIV     = 2;
    localparam int REP_W   = 3;
    localparam int FRAME_W = 25;
    localparam int FRAME_C = FRAME_W * 4 * DIV;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       keycode = '0;
    logic [REP_W-1:0] repeat_cnt = '0;
    logic             carrier_en, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ook_frame_tx #(.CLK_DIV(DIV), .REP_W(REP_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .keycode(keycode),
        .repeat_cnt(repeat_cnt), .carrier_en(carrier_en), .busy(busy), .done(done)
    );

    function automatic logic exp_level(input logic [7:0] key, input int k);
        logic [FRAME_W-1:0] fv;
        int slot, bitn, sub;
        fv   = {16'h0035, key, 1'b0};
        k    = k % FRAME_C;
        slot = k / DIV;
        bitn = slot / 4;
        sub  = slot % 4;
        return (sub == 0) || (fv[FRAME_W-1-bitn] && sub < 3);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R7 trace; R6 busy/done; R8 via inject
    task automatic run_frame(input logic [7:0] key, input int rep, input bit inject);
        int frames, total, bad_k, bad_a, bad_e;
        bit trace_ok, busy_ok;
        frames = (rep == 0) ? 1 : rep;
        total  = frames * FRAME_C;
        trace_ok = 1'b1; busy_ok = 1'b1;
        bad_k = 0; bad_a = 0; bad_e = 0;
        @(negedge clk);
        start = 1'b1; keycode = key; repeat_cnt = REP_W'(rep);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < total; k++) begin
            if (carrier_en !== exp_level(key, k) && trace_ok) begin
                trace_ok = 1'b0; bad_k = k; bad_a = carrier_en; bad_e = exp_level(key, k);
            end
            if (busy !== 1'b1 || done !== 1'b0) busy_ok = 1'b0;
            if (inject && k == 37) begin
                start = 1'b1; keycode = ~key; repeat_cnt = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!trace_ok)
            $display("trace mismatch at cycle %0d (key %0h rep %0d)", bad_k, key, rep);
        check(trace_ok, inject ? "R8" : (rep > 1 || rep == 0 ? "R7" : "R5"), bad_a, bad_e);
        check(busy_ok, "R6", 0, 1);
        check(done === 1'b1 && busy === 1'b0 && carrier_en === 1'b0, "R6", done, 1);
        @(negedge clk);
        check(done === 1'b0 && carrier_en === 1'b0, "R9", carrier_en, 0);
    endtask

    initial begin
        #900000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(carrier_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", carrier_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(carrier_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", busy, 0);
        // R2 R3 R4 R5: every keycode, single frame
        for (int key = 0; key < 256; key++) run_frame(8'(key), 1, 1'b0);
        // R7: repeat counts
        run_frame(8'h94, 0, 1'b0);
        run_frame(8'h91, 2, 1'b0);
        run_frame(8'h15, 3, 1'b0);
        // R8: start and keycode change while busy
        run_frame(8'h9A, 2, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule